// File: doc/BRIEF.md
# Multi-Register Stack Transfer Sequencer

This block carries out one instruction that saves a contiguous run of data registers (D0 to D7) and pointer registers (P0 to P5) onto a memory stack, or restores them from it. It moves one 32-bit word per transfer through a simple request/ready memory port. For each word it addresses the register file through a single index port, reading the register for a save or writing it for a restore. The stack pointer value is taken in when the instruction starts and written back only once, when the last word has moved.

A caller pulses `start` with the 16-bit instruction word and the current stack pointer. The sequencer then reports either `done` (with `sp_we` and the new pointer) or `illegal`. It has four states. `S_IDLE` waits for `start`. An illegal word moves it to `S_FAULT`, and a legal word moves it to `S_XFER`. `S_XFER` issues one memory access per register and stays on a register until `mem_ready` is seen. After the accepted access for the final register it moves to `S_FINISH`. `S_FINISH` and `S_FAULT` each last one cycle and then return to `S_IDLE`.

Register index encoding on `rf_idx`: data register Dn is n (0 to 7), and pointer register Pn is 8+n (8 to 13).

Top module: `stack_seq`

## Requirements
- R1: Instruction fields: bit 8 selects data registers, bit 7 selects pointer registers, bit 6 is the direction (1 save/push, 0 restore/pop), bits 5:3 give the lowest data index and bits 2:0 the lowest pointer index. A word with neither select bit set, or with the pointer select set and a lowest pointer index above 5, raises `illegal` for exactly one cycle, in the cycle after `start` is sampled. It makes no memory request and no stack pointer write.
- R2: A push visits the data registers from the lowest data index up to D7, then the pointer registers from the lowest pointer index up to P5. Each group is visited only when its select bit is set.
- R3: On a push, the k-th store (counting from 0) goes to address sp_in - 4*(k+1), with `mem_we` high and `mem_wdata` equal to the register named on `rf_idx`.
- R4: A pop visits the pointer registers from P5 down to the lowest pointer index, then the data registers from D7 down to the lowest data index. Each group is visited only when its select bit is set.
- R5: On a pop, the k-th load reads address sp_in + 4*k with `mem_we` low. The returned word is written into the register named on `rf_idx` in the cycle the load is accepted.
- R6: `done` and `sp_we` are high together for exactly one cycle, the cycle after the last access is accepted. `sp_out` then carries sp_in - 4*N for a push and sp_in + 4*N for a pop, where N is the number of registers moved.
- R7: While `mem_ready` is low, the request, address and direction hold and the sequencer does not move to the next register.
- R8: A `start` pulse that arrives while an instruction is in progress is ignored.
- R9: After reset no request, `done`, `illegal` or `sp_we` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin executing `instr` (sampled in S_IDLE only) |
| instr | input | 16 | Instruction word |
| sp_in | input | 32 | Stack pointer at start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Byte address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_ready` |
| mem_ready | input | 1 | Access accepted this cycle |
| rf_idx | output | 4 | Register index being transferred |
| rf_rd_data | input | 32 | Register file read data for `rf_idx` |
| rf_we | output | 1 | Register file write enable |
| rf_wr_data | output | 32 | Register file write data |
| sp_we | output | 1 | Stack pointer write-back strobe |
| sp_out | output | 32 | Final stack pointer |
| done | output | 1 | Legal instruction completed |
| illegal | output | 1 | Instruction rejected |

## Verification
The first access request appears in the cycle right after the `start` edge. An illegal word shows `illegal` in that same first cycle and never shows a request. `done` and the stack pointer strobe come exactly one cycle after the edge that accepts the final access. The bench samples on falling edges and counts cycles from the `start` edge. It records the cycle of the last accepted access and requires `done` on the very next sample, and it requires `illegal` on sample zero. A sweep over all 512 settings of the nine field bits, with 0 to 2 wait cycles per access, checks each access in order and then compares the whole register and memory models.

// File: rtl/stack_pkg.sv
package stack_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_XFER   = 2'd1,
        S_FINISH = 2'd2,
        S_FAULT  = 2'd3
    } seq_state_t;

    // field positions the decoder relies on
    localparam int BIT_D_EN  = 8;
    localparam int BIT_P_EN  = 7;
    localparam int BIT_PUSH  = 6;
    localparam int D_LO_LSB  = 3;
    localparam int P_LO_LSB  = 0;
    localparam int NUM_W     = 3;

    typedef struct packed {
        logic             ptr;
        logic [NUM_W-1:0] num;
    } reg_sel_t;
endpackage

// File: rtl/stack_decode.sv
module stack_decode
    import stack_pkg::*;
#(
    parameter int NUM_D = 8,
    parameter int NUM_P = 6
) (
    input  logic [15:0]      instr,
    output logic             d_en,
    output logic             p_en,
    output logic             push,
    output logic [NUM_W-1:0] d_lo,
    output logic [NUM_W-1:0] p_lo,
    output logic             bad,
    output reg_sel_t         first
);
    localparam logic [NUM_W-1:0] D_TOP = NUM_W'(NUM_D - 1);
    localparam logic [NUM_W-1:0] P_TOP = NUM_W'(NUM_P - 1);

    always_comb begin
        d_en = instr[BIT_D_EN];
        p_en = instr[BIT_P_EN];
        push = instr[BIT_PUSH];
        d_lo = instr[D_LO_LSB +: NUM_W];
        p_lo = instr[P_LO_LSB +: NUM_W];
        bad  = (!d_en && !p_en) || (p_en && (p_lo > P_TOP));
        if (push) begin
            first = d_en ? '{ptr: 1'b0, num: d_lo} : '{ptr: 1'b1, num: p_lo};
        end else begin
            first = p_en ? '{ptr: 1'b1, num: P_TOP} : '{ptr: 1'b0, num: D_TOP};
        end
    end
endmodule

// File: rtl/stack_step.sv
module stack_step
    import stack_pkg::*;
#(
    parameter int NUM_D = 8,
    parameter int NUM_P = 6
) (
    input  reg_sel_t         cur,
    input  logic             push,
    input  logic             d_en,
    input  logic             p_en,
    input  logic [NUM_W-1:0] d_lo,
    input  logic [NUM_W-1:0] p_lo,
    output reg_sel_t         next,
    output logic             last
);
    localparam logic [NUM_W-1:0] D_TOP = NUM_W'(NUM_D - 1);
    localparam logic [NUM_W-1:0] P_TOP = NUM_W'(NUM_P - 1);

    always_comb begin
        next = cur;
        last = 1'b0;
        if (push) begin
            if (!cur.ptr) begin
                if (cur.num == D_TOP) begin
                    if (p_en) next = '{ptr: 1'b1, num: p_lo};
                    else      last = 1'b1;
                end else begin
                    next.num = cur.num + NUM_W'(1);
                end
            end else begin
                if (cur.num == P_TOP) last = 1'b1;
                else                  next.num = cur.num + NUM_W'(1);
            end
        end else begin
            if (cur.ptr) begin
                if (cur.num == p_lo) begin
                    if (d_en) next = '{ptr: 1'b0, num: D_TOP};
                    else      last = 1'b1;
                end else begin
                    next.num = cur.num - NUM_W'(1);
                end
            end else begin
                if (cur.num == d_lo) last = 1'b1;
                else                 next.num = cur.num - NUM_W'(1);
            end
        end
    end
endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int NUM_D = 8,
    parameter int NUM_P = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [15:0]   instr,
    input  logic [AW-1:0] sp_in,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ready,
    output logic [3:0]    rf_idx,
    input  logic [DW-1:0] rf_rd_data,
    output logic          rf_we,
    output logic [DW-1:0] rf_wr_data,
    output logic          sp_we,
    output logic [AW-1:0] sp_out,
    output logic          done,
    output logic          illegal
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    seq_state_t       state_q;
    reg_sel_t         cur_q;
    logic [AW-1:0]    addr_q;
    logic             d_en_q, p_en_q, push_q;
    logic [NUM_W-1:0] d_lo_q, p_lo_q;

    logic             dec_d_en, dec_p_en, dec_push, dec_bad;
    logic [NUM_W-1:0] dec_d_lo, dec_p_lo;
    reg_sel_t         dec_first, step_next;
    logic             step_last;

    stack_decode #(.NUM_D(NUM_D), .NUM_P(NUM_P)) u_dec (
        .instr (instr),
        .d_en  (dec_d_en),
        .p_en  (dec_p_en),
        .push  (dec_push),
        .d_lo  (dec_d_lo),
        .p_lo  (dec_p_lo),
        .bad   (dec_bad),
        .first (dec_first)
    );

    stack_step #(.NUM_D(NUM_D), .NUM_P(NUM_P)) u_step (
        .cur  (cur_q),
        .push (push_q),
        .d_en (d_en_q),
        .p_en (p_en_q),
        .d_lo (d_lo_q),
        .p_lo (p_lo_q),
        .next (step_next),
        .last (step_last)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            addr_q  <= '0;
            d_en_q  <= 1'b0;
            p_en_q  <= 1'b0;
            push_q  <= 1'b0;
            d_lo_q  <= '0;
            p_lo_q  <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        if (dec_bad) begin
                            state_q <= S_FAULT;
                        end else begin
                            state_q <= S_XFER;
                            cur_q   <= dec_first;
                            addr_q  <= sp_in;
                            d_en_q  <= dec_d_en;
                            p_en_q  <= dec_p_en;
                            push_q  <= dec_push;
                            d_lo_q  <= dec_d_lo;
                            p_lo_q  <= dec_p_lo;
                        end
                    end
                end
                S_XFER: begin
                    if (mem_ready) begin
                        addr_q <= push_q ? (addr_q - STEP) : (addr_q + STEP);
                        if (step_last) state_q <= S_FINISH;
                        else           cur_q   <= step_next;
                    end
                end
                S_FINISH: state_q <= S_IDLE;
                S_FAULT:  state_q <= S_IDLE;
                default:  state_q <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        rf_we      = 1'b0;
        sp_we      = 1'b0;
        done       = 1'b0;
        illegal    = 1'b0;
        mem_addr   = push_q ? (addr_q - STEP) : addr_q;
        mem_wdata  = rf_rd_data;
        rf_wr_data = mem_rdata;
        rf_idx     = {cur_q.ptr, cur_q.num};
        sp_out     = addr_q;
        unique case (state_q)
            S_IDLE: ;
            S_XFER: begin
                mem_req = 1'b1;
                mem_we  = push_q;
                rf_we   = !push_q && mem_ready;
            end
            S_FINISH: begin
                done  = 1'b1;
                sp_we = 1'b1;
            end
            S_FAULT: illegal = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic          mem_ready,
    input logic [AW-1:0] mem_addr,
    input logic          rf_we,
    input logic          sp_we,
    input logic          done,
    input logic          illegal
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    p_push_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_we) |=> (!mem_req || (mem_we && mem_addr == $past(mem_addr) - STEP)));

    p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |=> (!mem_req || (!mem_we && mem_addr == $past(mem_addr) + STEP)));

    p_pop_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (mem_req && mem_ready && !mem_we));

    p_done_sp_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done == sp_we);

    p_done_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_fault_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!mem_req && !sp_we) ##1 !mem_req);

    p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, illegal, mem_req}));
endmodule

bind stack_seq stack_seq_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .rf_we     (rf_we),
    .sp_we     (sp_we),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/sim_stack_seq.sv
module sim_stack_seq;
    localparam int PERIOD = 10;
    localparam logic [31:0] SP0 = 32'h80;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] sp_in = SP0;
    logic        mem_req, mem_we, rf_we, sp_we, done, illegal;
    logic [31:0] mem_addr, mem_wdata, rf_wr_data, sp_out, rf_rd_data;
    logic [31:0] mem_rdata = '0;
    logic        mem_ready = 1'b0;
    logic [3:0]  rf_idx;

    logic [31:0] regs [16];
    logic [31:0] mem  [64];

    int errs = 0;
    int checks = 0;

    always #(PERIOD/2) clk = ~clk;

    stack_seq u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .sp_in(sp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_idx(rf_idx),
        .rf_rd_data(rf_rd_data), .rf_we(rf_we), .rf_wr_data(rf_wr_data),
        .sp_we(sp_we), .sp_out(sp_out), .done(done), .illegal(illegal)
    );

    assign rf_rd_data = regs[rf_idx];

    always @(posedge clk) begin
        if (rf_we) regs[rf_idx] <= rf_wr_data;
        if (mem_req && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic run_one(input logic [8:0] f, input int wait_n, input bit noise);
        bit d = f[8], p = f[7], psh = f[6];
        int dlo = int'(f[5:3]);
        int plo = int'(f[2:0]);
        bit bad = (!d && !p) || (p && plo > 5);
        int lst[14];
        int n = 0, k = 0, wc = 0, cyc = 0, last_acc = -10;
        bit fin = 0, seen_done = 0, seen_bad = 0;
        logic [31:0] exp_regs[16];
        logic [31:0] exp_mem[64];
        logic [31:0] a;
        for (int i = 0; i < 16; i++) begin
            regs[i] = 32'hA000_0000 + 32'(i * 32'h111) + {23'd0, f};
            exp_regs[i] = regs[i];
        end
        for (int i = 0; i < 64; i++) begin
            mem[i] = 32'h5000_0000 + 32'(i) + {15'd0, f, 8'd0};
            exp_mem[i] = mem[i];
        end
        if (psh) begin
            if (d) for (int i = dlo; i <= 7; i++) begin lst[n] = i; n++; end
            if (p) for (int i = plo; i <= 5; i++) begin lst[n] = 8 + i; n++; end
        end else begin
            if (p) for (int i = 5; i >= plo; i--) begin lst[n] = 8 + i; n++; end
            if (d) for (int i = 7; i >= dlo; i--) begin lst[n] = i; n++; end
        end
        if (!bad) for (int j = 0; j < n; j++) begin
            if (psh) begin
                a = SP0 - 32'(4 * (j + 1));
                exp_mem[a[7:2]] = regs[lst[j]];
            end else begin
                a = SP0 + 32'(4 * j);
                exp_regs[lst[j]] = mem[a[7:2]];
            end
        end
        instr = {7'd0, f};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!fin && cyc < 200) begin
            start = 1'b0;
            mem_ready = 1'b0;
            if (illegal) begin
                seen_bad = 1;
                fin = 1;
                check(bad && cyc == 0, "R1", "illegal timing", 32'(cyc), 0);
            end
            if (done) begin
                seen_done = 1;
                fin = 1;
                check(!bad && cyc == last_acc + 1, "R6", "done timing", 32'(cyc), 32'(last_acc + 1));
                check(sp_we && sp_out == (psh ? SP0 - 32'(4 * n) : SP0 + 32'(4 * n)),
                      "R6", "sp write-back", sp_out, psh ? SP0 - 32'(4 * n) : SP0 + 32'(4 * n));
            end
            if (mem_req) begin
                if (bad || k >= n) begin
                    check(0, "R1", "unexpected access", mem_addr, 0);
                end else begin
                    a = psh ? SP0 - 32'(4 * (k + 1)) : SP0 + 32'(4 * k);
                    check(rf_idx == 4'(lst[k]), psh ? "R2" : "R4", "register order",
                          {28'd0, rf_idx}, 32'(lst[k]));
                    check(mem_addr == a && mem_we == psh, psh ? "R3" : "R5", "address",
                          mem_addr, a);
                    if (psh) check(mem_wdata == regs[lst[k]], "R3", "store data", mem_wdata, regs[lst[k]]);
                    if (wc < wait_n) begin
                        wc++;
                    end else begin
                        wc = 0;
                        mem_ready = 1'b1;
                        mem_rdata = mem[mem_addr[7:2]];
                        last_acc = cyc;
                        k++;
                    end
                end
            end
            if (noise && cyc == 1) begin
                instr = 16'h01C8;
                start = 1'b1;
            end
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        mem_ready = 1'b0;
        check(fin, bad ? "R1" : "R6", "completion seen", 32'(fin), 1);
        check(!(mem_req || done || illegal || sp_we), "R6", "quiet after end",
              {28'd0, mem_req, done, illegal, sp_we}, 0);
        check(seen_bad == bad && seen_done == !bad, "R1", "outcome", 32'(seen_bad), 32'(bad));
        if (!bad) check(k == n, "R7", "access count", 32'(k), 32'(n));
        for (int i = 0; i < 16; i++)
            if (regs[i] !== exp_regs[i]) begin
                check(0, noise ? "R8" : "R5", $sformatf("reg %0d", i), regs[i], exp_regs[i]);
            end
        for (int i = 0; i < 64; i++)
            if (mem[i] !== exp_mem[i]) begin
                check(0, noise ? "R8" : "R3", $sformatf("mem word %0d", i), mem[i], exp_mem[i]);
            end
        checks++;
    endtask

    initial begin
        #(PERIOD * 190000);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) regs[i] = '0;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9: reset state
        check(!(mem_req || done || illegal || sp_we), "R9", "reset outputs",
              {28'd0, mem_req, done, illegal, sp_we}, 0);
        for (int f = 0; f < 512; f++) begin
            run_one(9'(f), f % 3, (f % 7) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule